// File: doc/BRIEF.md
# Infrared Remote Control Pulse Receiver

This block takes a demodulated infrared remote control signal on a single pin and turns it into a frame of data bits. The pin is sampled only on cycles where a slow sampling strobe is high, and every width is measured in whole strobe periods. An optional inversion stage flips the pin before any measurement. This lets a frame whose leader starts high be handled as a low-first frame.

A frame opens with a leader pulse. Its low part is checked against a programmable window. Its high part is also checked against a window, unless the high upper limit is zero, in which case only the low part counts. Each data bit spans one falling edge to the next. The bit is decoded by comparing that span with a threshold and stored LSB-first in a wide data register, next to a count of received bits. A frame ends when a bit span runs past a programmable maximum and the final low pulse is wide enough. One-cycle interrupt pulses mark an accepted leader and a completed frame. The block then waits for the next leader.

Top module: `ir_pulse_rx`

## Requirements
- R1: After reset both interrupt outputs are low, the data register and the bit count are zero, and the block waits for a leader.
- R2: When `invert_i` is 1, the pin is inverted before sampling, so an inverted waveform decodes exactly as its true form does with `invert_i` at 0.
- R3: A leader low width L (number of strobes sampled low) is accepted only when `lead_lo_min_i` <= L <= `lead_lo_max_i`. A leader outside that window is ignored: no interrupt fires, and the data and count stay as they were.
- R4: With `lead_hi_max_i` nonzero, the leader high width H must also satisfy `lead_hi_min_i` <= H <= `lead_hi_max_i`. The falling edge that ends the high part starts the first bit span.
- R5: With `lead_hi_max_i` = 0, only the low width of the leader is checked and `lead_hi_min_i` has no effect. The first falling edge after the leader starts the first bit span and produces no bit.
- R6: A bit span C is the number of strobes from one falling edge to the next. The bit decodes as 1 when C >= `bit_thresh_i` and as 0 otherwise.
- R7: The k-th decoded bit of a frame (counting from 0) is written to `data_o[k]` and the count increments. The count stops at 72, and any further bits are dropped.
- R8: An accepted leader raises `irq_leader_o` for one clock. In that same clock the data register and the count read zero.
- R9: When a bit span reaches `bit_max_i`+1 strobes with no falling edge, the frame ends. A span of exactly `bit_max_i` still decodes. If the most recent low pulse is at least `stop_lo_min_i` strobes wide, `irq_frame_o` pulses for one clock. Otherwise no interrupt fires. In both cases the block returns to waiting for a leader.
- R10: If the pin is still low when the span overruns, the block keeps waiting. `irq_frame_o` fires once the low run reaches `stop_lo_min_i`. If the pin rises first, the frame is dropped with no interrupt.
- R11: Width counters saturate at 255 and do not wrap. With `lead_lo_max_i` = 255, a leader low of any length at or above the minimum is accepted.
- R12: Pin activity on cycles without a strobe is not observed. Outputs change only in the clock after a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Sampling strobe, one clock wide |
| rx_i | input | 1 | Demodulated remote control signal |
| invert_i | input | 1 | Invert the pin before measurement |
| lead_lo_min_i | input | 8 | Leader low width, lower limit |
| lead_lo_max_i | input | 8 | Leader low width, upper limit |
| lead_hi_min_i | input | 8 | Leader high width, lower limit |
| lead_hi_max_i | input | 8 | Leader high width, upper limit (0 = low-only leader) |
| bit_thresh_i | input | 8 | Span at or above which a bit is 1 |
| bit_max_i | input | 8 | Longest valid bit span |
| stop_lo_min_i | input | 8 | Minimum width of the final low pulse |
| irq_leader_o | output | 1 | Leader accepted pulse |
| irq_frame_o | output | 1 | Frame complete pulse |
| data_o | output | 72 | Received bits, first bit in bit 0 |
| bit_count_o | output | 7 | Number of bits received |

## Verification
A controller stuck in the wrong phase shows up within one frame. Either an interrupt pulse goes missing or an extra one appears, or `bit_count_o` differs from the number of falling edges that close a bit. An off-by-one in a width counter shows at the exact window edges: a leader one strobe inside or outside a limit, a span equal to the threshold, and a span of exactly the maximum or one past it. These sweeps catch it within the first frame that hits the edge. Corrupted data storage is visible in `data_o` as soon as the frame ends. Mis-gated sampling changes the decoded result of a frame that has pin glitches between strobes.

// File: rtl/ir_rx_pkg.sv
// Package: shared types for the infrared pulse receiver.
// Assumes nothing beyond being compiled before the receiver modules.
package ir_rx_pkg;

    // Receiver phases: wait for leader, leader low, leader high, data bits, final low check.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LEAD_LO = 3'd1,
        ST_LEAD_HI = 3'd2,
        ST_DATA    = 3'd3,
        ST_STOP    = 3'd4
    } rx_state_e;

endpackage

// File: rtl/ir_edge_meter.sv
// Samples the (optionally inverted) pin on each strobe, reports its edges and
// tracks the width of the current or most recent low pulse.
// Assumes the pin is already synchronous to clk and free of noise.
module ir_edge_meter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rx_i,
    input  logic             invert_i,
    output logic             lvl_o,
    output logic             fall_o,
    output logic             rise_o,
    output logic [CNT_W-1:0] low_w_o
);

    logic             lvl_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] run_inc;

    assign lvl_o   = rx_i ^ invert_i;
    assign run_inc = (run_q == '1) ? run_q : run_q + 1'b1;
    assign fall_o  = tick_i & lvl_q & ~lvl_o;
    assign rise_o  = tick_i & ~lvl_q & lvl_o;

    // Width of the low pulse in progress (this sample included) or the one that just ended.
    always_comb begin
        if (!lvl_o)
            low_w_o = run_inc;
        else if (!lvl_q)
            low_w_o = run_q;
        else
            low_w_o = last_q;
    end

    // Previous sample, running low width and last completed low width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b1;
            run_q  <= '0;
            last_q <= '0;
        end else if (tick_i) begin
            lvl_q <= lvl_o;
            run_q <= lvl_o ? '0 : run_inc;
            if (lvl_o && !lvl_q)
                last_q <= run_q;
        end
    end

endmodule

// File: rtl/ir_rx_ctrl.sv
// Frame controller: checks the leader windows, measures bit spans from falling
// edge to falling edge, decides each bit and detects the end of the frame.
// Assumes edges and widths come from ir_edge_meter and are valid only on strobe cycles.
module ir_rx_ctrl
    import ir_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             lvl_i,
    input  logic             fall_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] low_w_i,
    input  logic [CNT_W-1:0] lead_lo_min_i,
    input  logic [CNT_W-1:0] lead_lo_max_i,
    input  logic [CNT_W-1:0] lead_hi_min_i,
    input  logic [CNT_W-1:0] lead_hi_max_i,
    input  logic [CNT_W-1:0] bit_thresh_i,
    input  logic [CNT_W-1:0] bit_max_i,
    input  logic [CNT_W-1:0] stop_lo_min_i,
    output logic             clr_o,
    output logic             push_o,
    output logic             bit_o,
    output logic             irq_leader_o,
    output logic             irq_frame_o
);

    rx_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic             armed_q, armed_d;
    logic             lead_d, frame_d;
    logic             lo_only, stop_ok;

    assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
    assign lo_only = (lead_hi_max_i == '0);
    assign stop_ok = (low_w_i >= stop_lo_min_i);
    assign bit_o   = (cnt_q >= bit_thresh_i);

    // Next-state decision, evaluated only on strobe cycles.
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        armed_d = armed_q;
        clr_o   = 1'b0;
        push_o  = 1'b0;
        lead_d  = 1'b0;
        frame_d = 1'b0;
        if (tick_i) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (fall_i) begin
                        st_d  = ST_LEAD_LO;
                        cnt_d = CNT_W'(1);
                    end
                end
                ST_LEAD_LO: begin
                    if (rise_i) begin
                        cnt_d = CNT_W'(1);
                        if (cnt_q >= lead_lo_min_i && cnt_q <= lead_lo_max_i) begin
                            if (lo_only) begin
                                st_d    = ST_DATA;
                                armed_d = 1'b0;
                                clr_o   = 1'b1;
                                lead_d  = 1'b1;
                            end else begin
                                st_d = ST_LEAD_HI;
                            end
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end else if (cnt_inc > lead_lo_max_i) begin
                        st_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                ST_LEAD_HI: begin
                    if (fall_i) begin
                        cnt_d = CNT_W'(1);
                        if (cnt_q >= lead_hi_min_i) begin
                            st_d    = ST_DATA;
                            armed_d = 1'b1;
                            clr_o   = 1'b1;
                            lead_d  = 1'b1;
                        end else begin
                            st_d = ST_LEAD_LO;
                        end
                    end else if (cnt_inc > lead_hi_max_i) begin
                        st_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                ST_DATA: begin
                    if (fall_i) begin
                        push_o  = armed_q;
                        armed_d = 1'b1;
                        cnt_d   = CNT_W'(1);
                    end else if (cnt_inc > bit_max_i) begin
                        if (stop_ok) begin
                            frame_d = 1'b1;
                            st_d    = ST_IDLE;
                        end else if (!lvl_i) begin
                            st_d = ST_STOP;
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                ST_STOP: begin
                    if (stop_ok) begin
                        frame_d = 1'b1;
                        st_d    = ST_IDLE;
                    end else if (lvl_i) begin
                        st_d = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State, width counter, arm flag and registered interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            cnt_q        <= '0;
            armed_q      <= 1'b0;
            irq_leader_o <= 1'b0;
            irq_frame_o  <= 1'b0;
        end else begin
            st_q         <= st_d;
            cnt_q        <= cnt_d;
            armed_q      <= armed_d;
            irq_leader_o <= lead_d;
            irq_frame_o  <= frame_d;
        end
    end

endmodule

// File: rtl/ir_bit_store.sv
// Holds the decoded bits of one frame, first bit in position 0, plus a count
// that stops at the register width. Assumes clr and push never coincide.
module ir_bit_store #(
    parameter int DATA_BITS = 72,
    localparam int BCNT_W = $clog2(DATA_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 push_i,
    input  logic                 bit_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic [BCNT_W-1:0]    count_o
);

    logic [DATA_BITS-1:0] wr_en;
    logic                 room;

    assign room = (count_o < BCNT_W'(DATA_BITS));

    // One write enable per bit position, selected by the current count.
    for (genvar gi = 0; gi < DATA_BITS; gi++) begin : g_wen
        assign wr_en[gi] = push_i && room && (count_o == BCNT_W'(gi));
    end

    // Data and count update: clear on a new leader, write one position per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            count_o <= '0;
        end else if (clr_i) begin
            data_o  <= '0;
            count_o <= '0;
        end else if (push_i && room) begin
            data_o  <= (data_o & ~wr_en) | (wr_en & {DATA_BITS{bit_i}});
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/ir_pulse_rx.sv
// Top of the infrared pulse receiver: edge meter, frame controller and bit store.
// Assumes tick_i is a one-clock strobe and all configuration is static during a frame.
module ir_pulse_rx #(
    parameter int CNT_W = 8,
    parameter int DATA_BITS = 72,
    localparam int BCNT_W = $clog2(DATA_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 rx_i,
    input  logic                 invert_i,
    input  logic [CNT_W-1:0]     lead_lo_min_i,
    input  logic [CNT_W-1:0]     lead_lo_max_i,
    input  logic [CNT_W-1:0]     lead_hi_min_i,
    input  logic [CNT_W-1:0]     lead_hi_max_i,
    input  logic [CNT_W-1:0]     bit_thresh_i,
    input  logic [CNT_W-1:0]     bit_max_i,
    input  logic [CNT_W-1:0]     stop_lo_min_i,
    output logic                 irq_leader_o,
    output logic                 irq_frame_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic [BCNT_W-1:0]    bit_count_o
);

    logic             lvl, fall, rise;
    logic [CNT_W-1:0] low_w;
    logic             clr, push, bit_val;

    ir_edge_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .rx_i    (rx_i),
        .invert_i(invert_i),
        .lvl_o   (lvl),
        .fall_o  (fall),
        .rise_o  (rise),
        .low_w_o (low_w)
    );

    ir_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .lvl_i        (lvl),
        .fall_i       (fall),
        .rise_i       (rise),
        .low_w_i      (low_w),
        .lead_lo_min_i(lead_lo_min_i),
        .lead_lo_max_i(lead_lo_max_i),
        .lead_hi_min_i(lead_hi_min_i),
        .lead_hi_max_i(lead_hi_max_i),
        .bit_thresh_i (bit_thresh_i),
        .bit_max_i    (bit_max_i),
        .stop_lo_min_i(stop_lo_min_i),
        .clr_o        (clr),
        .push_o       (push),
        .bit_o        (bit_val),
        .irq_leader_o (irq_leader_o),
        .irq_frame_o  (irq_frame_o)
    );

    ir_bit_store #(.DATA_BITS(DATA_BITS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .push_i (push),
        .bit_i  (bit_val),
        .data_o (data_o),
        .count_o(bit_count_o)
    );

endmodule

// File: rtl/ir_pulse_rx_chk.sv
// Checker for ir_pulse_rx: port-level rules on interrupts, count and strobe gating.
// Assumes it is bound to every instance of ir_pulse_rx.
module ir_pulse_rx_chk #(
    parameter int CNT_W = 8,
    parameter int DATA_BITS = 72,
    localparam int BCNT_W = $clog2(DATA_BITS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_i,
    input logic                 irq_leader_o,
    input logic                 irq_frame_o,
    input logic [DATA_BITS-1:0] data_o,
    input logic [BCNT_W-1:0]    bit_count_o
);

    AST_LEADER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_leader_o |-> (bit_count_o == '0 && data_o == '0)); // R8
    AST_LEADER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_leader_o |=> !irq_leader_o); // R8
    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_count_o <= BCNT_W'(DATA_BITS)); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_count_o) |-> (bit_count_o == '0 || bit_count_o == $past(bit_count_o) + BCNT_W'(1))); // R7
    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_frame_o |=> !irq_frame_o); // R9
    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_frame_o && irq_leader_o)); // R9
    AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(bit_count_o) && $stable(data_o) && !irq_frame_o && !irq_leader_o)); // R12

endmodule

bind ir_pulse_rx ir_pulse_rx_chk #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .irq_leader_o(irq_leader_o),
    .irq_frame_o (irq_frame_o),
    .data_o      (data_o),
    .bit_count_o (bit_count_o)
);

// File: tb/test_ir_pulse_rx.sv
`timescale 1ns/1ps
// Bench for ir_pulse_rx: sweeps leader widths, bit counts, spans and stop pulses.
module test_ir_pulse_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        rx_i = 1'b1;
    logic        invert_i = 1'b0;
    logic [7:0]  lo_min, lo_max, hi_min, hi_max, thr, bmax, stop_min;
    logic        irq_leader_o, irq_frame_o;
    logic [71:0] data_o;
    logic [6:0]  bit_count_o;

    int tests = 0;
    int fails = 0;
    int n_lead = 0;
    int n_frame = 0;

    always #4 clk = ~clk;

    ir_pulse_rx i_ir_pulse_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .rx_i         (rx_i),
        .invert_i     (invert_i),
        .lead_lo_min_i(lo_min),
        .lead_lo_max_i(lo_max),
        .lead_hi_min_i(hi_min),
        .lead_hi_max_i(hi_max),
        .bit_thresh_i (thr),
        .bit_max_i    (bmax),
        .stop_lo_min_i(stop_min),
        .irq_leader_o (irq_leader_o),
        .irq_frame_o  (irq_frame_o),
        .data_o       (data_o),
        .bit_count_o  (bit_count_o)
    );

    // Interrupt pulse counters.
    always @(posedge clk) begin
        if (irq_leader_o) n_lead <= n_lead + 1;
        if (irq_frame_o)  n_frame <= n_frame + 1;
    end

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One strobe with the given true level on the pin.
    task automatic step(input bit lvl);
        @(negedge clk);
        rx_i   = lvl ^ invert_i;
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic hold(input bit lvl, input int n);
        for (int k = 0; k < n; k++) step(lvl);
    endtask

    function automatic int cyc_of(input int seed, input int i);
        return 3 + ((i * 7 + seed) % 18);
    endfunction

    // Sends one frame and checks interrupts, count and data against arithmetic expectations.
    task automatic run_case(input string req, input int ll, input int x, input int n,
                            input int seed, input int long_at, input int e, input bit glitch,
                            input bit exp_lead, input bit exp_frame);
        int          l0, f0, ec, c;
        logic [6:0]  c0;
        logic [71:0] d0, ed;
        l0 = n_lead; f0 = n_frame; c0 = bit_count_o; d0 = data_o;
        ed = '0; ec = 0;
        hold(1'b1, 4);
        hold(1'b0, ll);
        if (glitch) begin
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                rx_i = ~rx_i;
            end
        end
        hold(1'b1, x);
        for (int i = 0; i < n; i++) begin
            c = (i == long_at) ? int'(bmax) + 1 : cyc_of(seed, i);
            hold(1'b0, 2);
            hold(1'b1, c - 2);
            if (long_at < 0 || i < long_at) begin
                if (ec < 72) begin
                    ed[ec] = (c >= int'(thr));
                    ec++;
                end
            end
            if (i == long_at) break;
        end
        hold(1'b0, e);
        hold(1'b1, 30);
        check({req, " leader irq"}, 72'(n_lead - l0), exp_lead ? 72'd1 : 72'd0);
        check({req, " frame irq"}, 72'(n_frame - f0), exp_frame ? 72'd1 : 72'd0);
        if (exp_lead) begin
            check({req, " count"}, 72'(bit_count_o), 72'(ec));
            check({req, " data"}, data_o, ed);
        end else begin
            check({req, " count kept"}, 72'(bit_count_o), 72'(c0));
            check({req, " data kept"}, data_o, d0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int nl[8] = '{0, 1, 5, 33, 71, 72, 73, 80};
        lo_min = 8'd10; lo_max = 8'd14; hi_min = 8'd6; hi_max = 8'd9;
        thr = 8'd6; bmax = 8'd20; stop_min = 8'd3;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 count", 72'(bit_count_o), 72'd0);
        check("R1 data", data_o, 72'd0);
        check("R1 irq", 72'({irq_leader_o, irq_frame_o}), 72'd0);

        // R7: bit count sweep including the 72-bit limit
        foreach (nl[j]) run_case("R7", 12, 7, nl[j], nl[j], -1, 3, 1'b0, 1'b1, 1'b1);
        // R6: spans straddling the threshold
        for (int s = 0; s < 4; s++) run_case("R6", 12, 7, 18, s, -1, 3, 1'b0, 1'b1, 1'b1);
        // R8: a new leader clears bits of a longer earlier frame
        run_case("R8", 12, 7, 40, 1, -1, 3, 1'b0, 1'b1, 1'b1);
        run_case("R8", 12, 7, 3, 2, -1, 3, 1'b0, 1'b1, 1'b1);
        // R3: leader low window edges
        for (int ll = 8; ll <= 16; ll++)
            run_case("R3", ll, 7, 4, ll, -1, 3, 1'b0, (ll >= 10 && ll <= 14), (ll >= 10 && ll <= 14));
        // R4: leader high window edges
        for (int x = 4; x <= 11; x++)
            run_case("R4", 12, x, 4, x, -1, 3, 1'b0, (x >= 6 && x <= 9), (x >= 6 && x <= 9));
        // R9: final low width against the stop minimum
        for (int e = 1; e <= 5; e++) run_case("R9", 12, 7, 6, e, -1, e, 1'b0, 1'b1, (e >= 3));
        // R9: a span one past the maximum ends the frame early
        run_case("R9 overrun", 12, 7, 6, 0, 2, 3, 1'b0, 1'b1, 1'b0);
        // R10: still low at overrun, waits for the low run
        stop_min = 8'd25;
        run_case("R10 pass", 12, 7, 4, 3, -1, 30, 1'b0, 1'b1, 1'b1);
        run_case("R10 fail", 12, 7, 4, 4, -1, 23, 1'b0, 1'b1, 1'b0);
        stop_min = 8'd3;
        // R11: saturated leader width with the upper limit at 255
        lo_max = 8'd255;
        run_case("R11", 300, 7, 5, 5, -1, 3, 1'b0, 1'b1, 1'b1);
        lo_max = 8'd14;
        // R12: pin toggling between strobes is ignored
        run_case("R12", 12, 7, 8, 6, -1, 3, 1'b1, 1'b1, 1'b1);
        // R2: inverted pin
        @(negedge clk);
        invert_i = 1'b1;
        rx_i = 1'b0;
        run_case("R2", 12, 7, 20, 7, -1, 3, 1'b0, 1'b1, 1'b1);
        run_case("R2", 12, 5, 4, 8, -1, 3, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        invert_i = 1'b0;
        rx_i = 1'b1;
        // R5: low-only leader, high part and high minimum ignored
        hi_max = 8'd0; hi_min = 8'd50;
        for (int x = 1; x <= 15; x += 2) run_case("R5", 12, x, 6, x, -1, 3, 1'b0, 1'b1, 1'b1);
        run_case("R5 low window", 16, 7, 6, 9, -1, 3, 1'b0, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule